// File: doc/BRIEF.md
# Masked Associative Search Memory

This block is a small content-addressable store. It holds a parameterised number of words, and each entry carries a valid flag. A write port loads a word into an addressed entry and marks that entry valid. A separate input clears the valid flag of an addressed entry.

A search presents a pattern together with a mask. In a single cycle, every valid entry is compared with the pattern. Only the bit positions where the mask holds a 1 take part in the comparison.

The result is registered one cycle after the search strobe. It consists of:
- a hit or miss status;
- a flag that is raised when more than one entry matched;
- the index of the chosen entry;
- a full copy of the chosen stored word.

When several entries match, a fixed-priority resolver picks the entry with the lowest index. On a miss, the index and word outputs read zero. Between searches the result registers keep their last value.

Top module: `masked_cam`

## Requirements
- R1: After reset, resValid, resHit, resMulti, resIdx and resWord are all 0, and every entry is invalid, so a search with an all-zero mask misses.
- R2: A write with wrEn=1 stores wrData into entry wrIdx at the clock edge and sets that entry's valid flag.
- R3: Only pattern bits whose mask bit is 1 are compared; bits with mask 0 are ignored, and an all-zero mask matches every valid entry.
- R4: An entry whose valid flag is clear never matches; invEn=1 clears the valid flag of entry invIdx.
- R5: resValid is 1 for exactly the cycle after a clock edge that sampled srchEn=1, and 0 otherwise; the result outputs change only at such edges.
- R6: On a hit, resHit=1, resIdx gives the chosen entry's index and resWord gives that entry's complete stored word, including the masked-out bits.
- R7: On a miss, resHit=0, resMulti=0, resIdx=0 and resWord=0.
- R8: When more than one valid entry matches, the lowest-indexed one is chosen and resMulti=1; with a single match resMulti=0.
- R9: A write and a search in the same cycle compare against the entry contents held before the write.
- R10: A write and an invalidate to the same entry in the same cycle leave the entry valid with the new word; to different entries both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | IDX_W | Entry to write |
| wrData | input | WIDTH | Word to store |
| invEn | input | 1 | Invalidate strobe |
| invIdx | input | IDX_W | Entry to invalidate |
| srchEn | input | 1 | Search strobe |
| srchPattern | input | WIDTH | Pattern to search for |
| srchMask | input | WIDTH | 1 marks a compared bit |
| resValid | output | 1 | Result produced by the previous edge's search |
| resHit | output | 1 | At least one entry matched |
| resMulti | output | 1 | More than one entry matched |
| resIdx | output | IDX_W | Index of the chosen entry |
| resWord | output | WIDTH | Copy of the chosen stored word |

## Verification
The store is preloaded with overlapping words. Searches are then run with four kinds of mask:
- Full masks tell a single exact hit apart from an exact miss.
- Nibble and byte masks make several entries match at once, which exposes which entry the resolver picks and whether the multi-match flag is set.
- An all-zero mask shows that masked-out bits never veto a match.
- A mask with one low bit clear shows a match that depends on that bit being ignored.

An invalidated entry that holds a word equal to the pattern shows that the valid gating works. Same-cycle write-with-search and write-with-invalidate cases pin down the ordering rules.

// File: rtl/cam_pkg.sv
package cam_pkg;

  // Strobes issued by the control half to the datapath half
  typedef struct packed {
    logic wrStb;
    logic invStb;
    logic srchStb;
  } camStrobes_t;

endpackage

// File: rtl/cam_prio_resolver.sv
module cam_prio_resolver #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyReq,
  output logic             multiReq
);

  // Isolate the lowest set bit; anything left over means a second match
  always_comb begin
    grant    = req & (~req + N'(1));
    anyReq   = |req;
    multiReq = |(req & ~grant);
    grantIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) grantIdx = grantIdx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl import cam_pkg::*; #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             invEn,
  input  logic [IDX_W-1:0] invIdx,
  input  logic             srchEn,
  output camStrobes_t      stb,
  output logic             resValid
);

  logic sameEntry;

  // A write to the entry being invalidated takes precedence
  always_comb begin
    sameEntry   = wrEn && invEn && (wrIdx == invIdx);
    stb.wrStb   = wrEn;
    stb.invStb  = invEn && !sameEntry;
    stb.srchStb = srchEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= srchEn;
  end

endmodule

// File: rtl/cam_datapath.sv
module cam_datapath import cam_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  camStrobes_t      stb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDX_W-1:0] invIdx,
  input  logic [WIDTH-1:0] srchPattern,
  input  logic [WIDTH-1:0] srchMask,
  output logic             resHit,
  output logic             resMulti,
  output logic [IDX_W-1:0] resIdx,
  output logic [WIDTH-1:0] resWord
);

  logic [WIDTH-1:0]   words [ENTRIES];
  logic [ENTRIES-1:0] entryValid;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] grantVec;
  logic [IDX_W-1:0]   grantIdx;
  logic               anyMatch;
  logic               multiMatch;
  logic [WIDTH-1:0]   selWord;

  // Storage: word contents are not reset, only the valid flags are
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (stb.wrStb && wrIdx == IDX_W'(e)) words[e] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (stb.invStb && invIdx == IDX_W'(e)) entryValid[e] <= 1'b0;
        if (stb.wrStb  && wrIdx  == IDX_W'(e)) entryValid[e] <= 1'b1;
      end
    end
  end

  // One masked comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : gCompare
    assign matchVec[g] = entryValid[g] &&
                         (((words[g] ^ srchPattern) & srchMask) == '0);
  end

  cam_prio_resolver #(.N(ENTRIES)) uResolver (
    .req      (matchVec),
    .grant    (grantVec),
    .grantIdx (grantIdx),
    .anyReq   (anyMatch),
    .multiReq (multiMatch)
  );

  // One-hot AND-OR selection of the granted word
  always_comb begin
    selWord = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grantVec[e]) selWord = selWord | words[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHit   <= 1'b0;
      resMulti <= 1'b0;
      resIdx   <= '0;
      resWord  <= '0;
    end else if (stb.srchStb) begin
      resHit   <= anyMatch;
      resMulti <= multiMatch;
      resIdx   <= grantIdx;
      resWord  <= selWord;
    end
  end

endmodule

// File: rtl/masked_cam.sv
module masked_cam import cam_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic             invEn,
  input  logic [IDX_W-1:0] invIdx,
  input  logic             srchEn,
  input  logic [WIDTH-1:0] srchPattern,
  input  logic [WIDTH-1:0] srchMask,
  output logic             resValid,
  output logic             resHit,
  output logic             resMulti,
  output logic [IDX_W-1:0] resIdx,
  output logic [WIDTH-1:0] resWord
);

  camStrobes_t stb;

  cam_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .invEn    (invEn),
    .invIdx   (invIdx),
    .srchEn   (srchEn),
    .stb      (stb),
    .resValid (resValid)
  );

  cam_datapath #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX_W(IDX_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrIdx       (wrIdx),
    .wrData      (wrData),
    .invIdx      (invIdx),
    .srchPattern (srchPattern),
    .srchMask    (srchMask),
    .resHit      (resHit),
    .resMulti    (resMulti),
    .resIdx      (resIdx),
    .resWord     (resWord)
  );

endmodule

// File: rtl/masked_cam_checker.sv
module masked_cam_checker #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             srchEn,
  input logic [WIDTH-1:0] srchPattern,
  input logic [WIDTH-1:0] srchMask,
  input logic             resValid,
  input logic             resHit,
  input logic             resMulti,
  input logic [IDX_W-1:0] resIdx,
  input logic [WIDTH-1:0] resWord
);

  p_search_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    srchEn |=> resValid);

  p_idle_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> !resValid);

  p_hold_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> ($stable(resWord) && $stable(resHit) && $stable(resIdx)));

  p_masked_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |->
      ((($past(srchPattern) ^ resWord) & $past(srchMask)) == '0));

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resWord == '0 && resIdx == '0 && !resMulti));

  p_multi_needs_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    resMulti |-> resHit);

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    resHit |-> (int'(resIdx) < ENTRIES));

endmodule

bind masked_cam masked_cam_checker #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) uChecker (.*);

// File: tb/masked_cam_test.sv
`timescale 1ns/1ps
module masked_cam_test;

  localparam int ENTRIES = 8;
  localparam int WIDTH   = 16;
  localparam int IDX_W   = 3;

  typedef struct packed {
    logic [WIDTH-1:0] pat;
    logic [WIDTH-1:0] msk;
    logic             hit;
    logic             multi;
    logic [IDX_W-1:0] idx;
    logic [WIDTH-1:0] word;
  } vec_t;

  // Entries: 0=A5C3 1=12F0 2=34F0 3=A5FF 5=BEEF; 6 written as 0000 then invalidated
  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{16'h12F0, 16'hFFFF, 1'b1, 1'b0, 3'd1, 16'h12F0},  // R6 single exact hit
    '{16'h00F0, 16'h00FF, 1'b1, 1'b1, 3'd1, 16'h12F0},  // R8 entries 1,2 match
    '{16'hA500, 16'hFF00, 1'b1, 1'b1, 3'd0, 16'hA5C3},  // R8 entries 0,3 match
    '{16'h0000, 16'hFFFF, 1'b0, 1'b0, 3'd0, 16'h0000},  // R4 invalid entry 6
    '{16'h1234, 16'h0000, 1'b1, 1'b1, 3'd0, 16'hA5C3},  // R3 zero mask
    '{16'hBEEF, 16'hFFFF, 1'b1, 1'b0, 3'd5, 16'hBEEF},  // R6 hit at entry 5
    '{16'hFFFF, 16'h0F00, 1'b0, 1'b0, 3'd0, 16'h0000},  // R7 miss
    '{16'h34F1, 16'hFFFE, 1'b1, 1'b0, 3'd2, 16'h34F0}   // R3 ignored low bit
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn, invEn, srchEn;
  logic [IDX_W-1:0] wrIdx, invIdx;
  logic [WIDTH-1:0] wrData, srchPattern, srchMask;
  logic             resValid, resHit, resMulti;
  logic [IDX_W-1:0] resIdx;
  logic [WIDTH-1:0] resWord;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  masked_cam #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) uut (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .invEn(invEn), .invIdx(invIdx),
    .srchEn(srchEn), .srchPattern(srchPattern), .srchMask(srchMask),
    .resValid(resValid), .resHit(resHit), .resMulti(resMulti),
    .resIdx(resIdx), .resWord(resWord)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkResult(input string req, input logic hit, input logic multi,
                           input logic [IDX_W-1:0] idx, input logic [WIDTH-1:0] word);
    chk(req, "resValid", 32'(resValid), 32'd1);
    chk(req, "resHit",   32'(resHit),   32'(hit));
    chk(req, "resMulti", 32'(resMulti), 32'(multi));
    chk(req, "resIdx",   32'(resIdx),   32'(idx));
    chk(req, "resWord",  32'(resWord),  32'(word));
  endtask

  task automatic doWrite(input logic [IDX_W-1:0] idx, input logic [WIDTH-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doInvalidate(input logic [IDX_W-1:0] idx);
    @(negedge clk);
    invEn = 1'b1; invIdx = idx;
    @(negedge clk);
    invEn = 1'b0;
  endtask

  // Search is sampled at the posedge between the two negedges; result checked at the second
  task automatic doSearch(input logic [WIDTH-1:0] pat, input logic [WIDTH-1:0] msk);
    @(negedge clk);
    srchEn = 1'b1; srchPattern = pat; srchMask = msk;
    @(negedge clk);
    srchEn = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; invEn = 1'b0; srchEn = 1'b0;
    wrIdx = '0; invIdx = '0; wrData = '0; srchPattern = '0; srchMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1", "resValid", 32'(resValid), 32'd0);
    chk("R1", "resHit",   32'(resHit),   32'd0);
    chk("R1", "resWord",  32'(resWord),  32'd0);
    doSearch(16'h0000, 16'h0000);
    chkResult("R1", 1'b0, 1'b0, 3'd0, 16'h0000);

    // R2: preload
    doWrite(3'd0, 16'hA5C3);
    doWrite(3'd1, 16'h12F0);
    doWrite(3'd2, 16'h34F0);
    doWrite(3'd3, 16'hA5FF);
    doWrite(3'd5, 16'hBEEF);
    doWrite(3'd6, 16'h0000);
    doSearch(16'h0000, 16'hFFFF);
    chkResult("R2", 1'b1, 1'b0, 3'd6, 16'h0000);
    doInvalidate(3'd6);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      doSearch(TBL[v].pat, TBL[v].msk);
      chkResult($sformatf("R6/R8 vec%0d", v), TBL[v].hit, TBL[v].multi,
                TBL[v].idx, TBL[v].word);
    end

    // R5: result holds and valid drops with no search
    @(negedge clk);
    chk("R5", "resValid idle", 32'(resValid), 32'd0);
    chk("R5", "resWord held",  32'(resWord),  32'h34F0);
    chk("R5", "resIdx held",   32'(resIdx),   32'd2);

    // R9: write and search the same entry in one cycle -> old contents
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd1; wrData = 16'h7777;
    srchEn = 1'b1; srchPattern = 16'h12F0; srchMask = 16'hFFFF;
    @(negedge clk);
    wrEn = 1'b0; srchEn = 1'b0;
    chkResult("R9", 1'b1, 1'b0, 3'd1, 16'h12F0);
    doSearch(16'h7777, 16'hFFFF);
    chkResult("R9", 1'b1, 1'b0, 3'd1, 16'h7777);

    // R10: write and invalidate on the same entry -> write wins
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd4; wrData = 16'h4444;
    invEn = 1'b1; invIdx = 3'd4;
    @(negedge clk);
    wrEn = 1'b0; invEn = 1'b0;
    doSearch(16'h4444, 16'hFFFF);
    chkResult("R10", 1'b1, 1'b0, 3'd4, 16'h4444);

    // R10: write and invalidate on different entries -> both act
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd7; wrData = 16'h7E7E;
    invEn = 1'b1; invIdx = 3'd5;
    @(negedge clk);
    wrEn = 1'b0; invEn = 1'b0;
    doSearch(16'hBEEF, 16'hFFFF);
    chkResult("R10 R4", 1'b0, 1'b0, 3'd0, 16'h0000);
    doSearch(16'h7E7E, 16'hFFFF);
    chkResult("R10", 1'b1, 1'b0, 3'd7, 16'h7E7E);

    // R4: invalidating entry 0 moves the zero-mask winner to entry 1
    doInvalidate(3'd0);
    doSearch(16'h0000, 16'h0000);
    chkResult("R4", 1'b1, 1'b1, 3'd1, 16'h7777);

    // R1: reset clears stored valid flags
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1", "resHit after reset", 32'(resHit), 32'd0);
    doSearch(16'h0000, 16'h0000);
    chkResult("R1", 1'b0, 1'b0, 3'd0, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule